// File: doc/BRIEF.md
# Three-Byte SPI Command Frame Sequencer

This block drives a byte-wide SPI master so that a 24-bit command reaches a slave as one framed transaction. A single-cycle start strobe hands over the command word and an idle-hold count. The word is moved up by a fixed left shift of six positions and cut into three bytes. The sequencer pulls the active-low chip select down, feeds the bytes to the master one at a time, and releases chip select only once the last byte has finished shifting.

The master gives back two indications: a buffer-empty flag that says another byte may be loaded, and a sticky byte-complete flag that stays high until the sequencer pulses a clear. The sequencer loads a byte only while the buffer is empty. It then waits for the complete flag and clears it before it loads the next byte. Buffer-empty alone therefore never ends a frame, and a flag left over from earlier traffic is flushed when the frame opens. A programmable number of idle clocks separates the final completion from the chip select edge, and a one-cycle done pulse marks that edge.

Top module: `spi_frame_writer`

## Requirements
- R1: After reset cs_n is high, and busy, done, tx_load and tx_clr are all low.
- R2: A start pulse sampled while idle drives cs_n low and busy high from the next cycle. tx_clr pulses in that same cycle. The first tx_load is no earlier than two cycles after cs_n falls.
- R3: The frame is (word << 6) truncated to 24 bits. Its bits [23:16], [15:8] and [7:0] are presented on tx_byte in that order, each valid in the cycle its tx_load is high.
- R4: tx_load is a single-cycle pulse. It is issued only on the edge after tx_empty was sampled high.
- R5: After a tx_load, no further tx_load occurs until byte_done has been sampled high and tx_clr has been pulsed, in the cycle after that sample.
- R6: A byte_done flag that is already high when a frame starts is cleared by the start-of-frame tx_clr. It does not advance the sequence.
- R7: cs_n stays low from the start of the frame through every byte. It rises exactly hold+2 clock edges after the edge at which the last byte_done is sampled high, where hold is the hold_cycles value captured at start.
- R8: done is high for exactly one cycle, the first cycle in which cs_n is high again. busy is low in that cycle.
- R9: A start pulse that arrives while busy has no effect on the frame in progress. It does not begin a new frame afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (one cycle) |
| word | input | 24 | Command value, captured at start |
| hold_cycles | input | 4 | Idle clocks before chip select release, captured at start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse as chip select releases |
| cs_n | output | 1 | Active-low slave select |
| tx_byte | output | 8 | Byte presented to the SPI master |
| tx_load | output | 1 | Load strobe for tx_byte |
| tx_empty | input | 1 | Master transmit buffer empty |
| byte_done | input | 1 | Sticky byte shift-complete flag |
| tx_clr | output | 1 | Clear pulse for byte_done |

## Verification
The bench drives a behavioural byte master with adjustable shift length and buffer-empty delay. Against it the bench sweeps walking-one and pattern words, so that a wrong shift, a truncation error or a swapped byte order shows up as a mismatched byte. It leaves a stale completion flag up before a frame starts: a sequencer that never flushes the flag would load the second byte while the first is still shifting and close the frame early. Holding buffer-empty low after completion catches a sequencer that loads into a full buffer. Measuring the chip select edge against the last completion catches a release on buffer-empty or a wrong hold count. A start pulse injected mid-frame shows whether a busy sequencer restarts or queues a second frame.

// File: rtl/spi_fw_pkg.sv
package spi_fw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_SEND,
    ST_WAIT_DONE,
    ST_CS_HOLD,
    ST_FINISH
  } fw_state_e;
endpackage

// File: rtl/spi_fw_aligner.sv
// Shifts the captured word up and slices it into bytes, slot 0 sent first.
module spi_fw_aligner #(
  parameter int WORD_W    = 24,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int SHIFT     = 6
) (
  input  logic [WORD_W-1:0]                  word,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0]   slots
);
  localparam int FRAME_W = NUM_BYTES * BYTE_W;
  localparam int EXT_W   = (WORD_W + SHIFT > FRAME_W) ? WORD_W + SHIFT : FRAME_W;

  logic [EXT_W-1:0]   ext;
  logic [FRAME_W-1:0] frame;

  assign ext   = EXT_W'(word) << SHIFT;
  assign frame = ext[FRAME_W-1:0];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slot
    assign slots[i] = frame[FRAME_W-1-i*BYTE_W -: BYTE_W];
  end
endmodule

// File: rtl/spi_fw_hold_timer.sv
// Down-counter for the idle gap before chip select release.
module spi_fw_hold_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              dec,
  input  logic [HOLD_W-1:0] value,
  output logic              zero
);
  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= value;
    end else if (dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/spi_fw_ctrl.sv
// Frame state machine with registered strobes and chip select.
module spi_fw_ctrl
  import spi_fw_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  parameter int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tx_empty,
  input  logic             byte_done,
  input  logic             hold_zero,
  output logic             latch_en,
  output logic             issue,
  output logic             hold_load,
  output logic             hold_dec,
  output logic [SEL_W-1:0] sel,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic             tx_load,
  output logic             tx_clr
);
  fw_state_e state;
  logic      last;

  assign last = (sel == SEL_W'(NUM_BYTES - 1));

  always_comb begin
    latch_en  = (state == ST_IDLE) && start;
    issue     = (state == ST_SEND) && tx_empty;
    hold_load = (state == ST_WAIT_DONE) && byte_done && last;
    hold_dec  = (state == ST_CS_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sel     <= '0;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      tx_load <= 1'b0;
      tx_clr  <= 1'b0;
    end else begin
      done    <= 1'b0;
      tx_load <= 1'b0;
      tx_clr  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_CS_SETUP;
            cs_n   <= 1'b0;
            busy   <= 1'b1;
            tx_clr <= 1'b1;   // flush any stale completion flag
            sel    <= '0;
          end
        end
        ST_CS_SETUP: state <= ST_SEND;
        ST_SEND: begin
          if (tx_empty) begin
            tx_load <= 1'b1;
            state   <= ST_WAIT_DONE;
          end
        end
        ST_WAIT_DONE: begin
          if (byte_done) begin
            tx_clr <= 1'b1;
            if (last) begin
              state <= ST_CS_HOLD;
            end else begin
              sel   <= sel + 1'b1;
              state <= ST_SEND;
            end
          end
        end
        ST_CS_HOLD: begin
          if (hold_zero) state <= ST_FINISH;
        end
        ST_FINISH: begin
          cs_n  <= 1'b1;
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_writer.sv
module spi_frame_writer #(
  parameter int WORD_W    = 24,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int SHIFT     = 6,
  parameter int HOLD_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_load,
  input  logic              tx_empty,
  input  logic              byte_done,
  output logic              tx_clr
);
  localparam int SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [WORD_W-1:0]                word_q;
  logic [HOLD_W-1:0]                hold_q;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] slots;
  logic [SEL_W-1:0]                 sel;
  logic latch_en, issue, hold_load, hold_dec, hold_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      hold_q <= '0;
    end else if (latch_en) begin
      word_q <= word;
      hold_q <= hold_cycles;
    end
  end

  spi_fw_aligner #(
    .WORD_W(WORD_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .SHIFT(SHIFT)
  ) u_align (
    .word (word_q),
    .slots(slots)
  );

  spi_fw_ctrl #(.NUM_BYTES(NUM_BYTES), .SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tx_empty (tx_empty),
    .byte_done(byte_done),
    .hold_zero(hold_zero),
    .latch_en (latch_en),
    .issue    (issue),
    .hold_load(hold_load),
    .hold_dec (hold_dec),
    .sel      (sel),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done),
    .tx_load  (tx_load),
    .tx_clr   (tx_clr)
  );

  spi_fw_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (hold_load),
    .dec  (hold_dec),
    .value(hold_q),
    .zero (hold_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte <= '0;
    end else if (issue) begin
      tx_byte <= slots[sel];
    end
  end
endmodule

// File: rtl/spi_frame_writer_chk.sv
module spi_frame_writer_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic tx_load,
  input logic tx_empty,
  input logic byte_done,
  input logic tx_clr
);
  // R2
  frame_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!cs_n && tx_clr));

  // R4
  load_after_empty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(tx_empty));

  // R4
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);

  // R5
  clear_after_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_clr && !$rose(busy)) |-> $past(byte_done));

  // R5
  no_load_with_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_load && tx_clr));

  // R7
  load_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (!cs_n && busy));

  // R8
  done_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(!cs_n) && !busy));

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind spi_frame_writer spi_frame_writer_chk u_chk (.*);

// File: tb/spi_frame_writer_tb.sv
module spi_frame_writer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] word = '0;
  logic [3:0]  hold_cycles = '0;
  logic        busy, done, cs_n, tx_load, tx_clr;
  logic [7:0]  tx_byte;
  logic        tx_empty;
  logic        byte_done;

  int nchecks = 0;
  int nerrors = 0;
  int cyc = 0;

  // byte master model configuration (written by the stimulus only)
  int s_cfg = 2;
  int d_cfg = 1;
  int stale_req = 0;

  // model state (written by the model only)
  int shift_left = 0;
  int empty_left = 0;
  int nbytes = 0;
  int last_set = 0;
  int merr_empty = 0;
  int merr_order = 0;
  int merr_cs = 0;
  int stale_ack = 0;
  logic [7:0] cap [0:7];

  always #4 clk = ~clk;

  spi_frame_writer u_dut (
    .clk(clk), .rst(rst), .start(start), .word(word), .hold_cycles(hold_cycles),
    .busy(busy), .done(done), .cs_n(cs_n), .tx_byte(tx_byte), .tx_load(tx_load),
    .tx_empty(tx_empty), .byte_done(byte_done), .tx_clr(tx_clr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural byte master, updated away from the active edge.
  initial begin
    tx_empty  = 1'b1;
    byte_done = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (tx_clr) byte_done = 1'b0;
        if (stale_req != stale_ack) begin
          byte_done = 1'b1;
          stale_ack = stale_req;
        end
        if (tx_load) begin
          if (!tx_empty) merr_empty++;
          if (shift_left != 0 || byte_done) merr_order++;
          if (cs_n) merr_cs++;
          cap[nbytes % 8] = tx_byte;
          nbytes++;
          tx_empty   = 1'b0;
          shift_left = s_cfg;
          empty_left = d_cfg;
        end else begin
          if (shift_left > 0) begin
            shift_left--;
            if (shift_left == 0) begin
              if (cs_n) merr_cs++;
              byte_done = 1'b1;
              last_set  = cyc;
            end
          end
          if (empty_left > 0) begin
            empty_left--;
            if (empty_left == 0) tx_empty = 1'b1;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [23:0] v, input int h, input int s,
                           input int d, input bit stale, input int inj);
    logic [23:0] sh;
    int base, me, mo, mc, k;
    bit seen;
    sh = v << 6;
    s_cfg = s;
    d_cfg = d;
    if (stale) begin
      stale_req = stale_req + 1;
      @(negedge clk);
      @(negedge clk);
      chk(byte_done == 1'b1 && cs_n == 1'b1, "R6", "stale flag ignored while idle",
          {byte_done, cs_n}, 2'b11);
    end
    base = nbytes;
    me = merr_empty; mo = merr_order; mc = merr_cs;
    @(negedge clk);
    word = v;
    hold_cycles = 4'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    word = ~v;
    chk(cs_n == 1'b0 && busy == 1'b1 && tx_clr == 1'b1 && tx_load == 1'b0, "R2",
        "frame open (cs_n,busy,tx_clr,tx_load)",
        {cs_n, busy, tx_clr, tx_load}, 4'b0110);
    if (stale) begin
      @(negedge clk);
      chk(byte_done == 1'b0 && tx_load == 1'b0, "R6", "stale flag flushed, no load",
          {byte_done, tx_load}, 2'b00);
    end
    seen = 1'b0;
    k = 0;
    while (!seen && k < 2000) begin
      if (cs_n) seen = 1'b1;
      else begin
        if (inj != 0 && k == inj) start = 1'b1;
        else start = 1'b0;
        @(negedge clk);
        k++;
      end
    end
    start = 1'b0;
    chk(seen, "R7", "chip select released", seen, 1);
    chk(nbytes - base == 3, "R9", "bytes per frame", nbytes - base, 3);
    chk(cap[base % 8] == sh[23:16], "R3", "first byte", cap[base % 8], sh[23:16]);
    chk(cap[(base + 1) % 8] == sh[15:8], "R3", "second byte", cap[(base + 1) % 8], sh[15:8]);
    chk(cap[(base + 2) % 8] == sh[7:0], "R3", "third byte", cap[(base + 2) % 8], sh[7:0]);
    chk(merr_empty == me, "R4", "loads into full buffer", merr_empty - me, 0);
    chk(merr_order == mo, "R5", "loads before completion acked", merr_order - mo, 0);
    chk(merr_cs == mc, "R7", "cs_n high during a byte", merr_cs - mc, 0);
    chk(cyc - last_set == h + 3, "R7", "cs release delay after last completion",
        cyc - last_set - 1, h + 2);
    chk(done == 1'b1 && busy == 1'b0, "R8", "done with release (done,busy)",
        {done, busy}, 2'b10);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", done, 0);
    if (inj != 0) begin
      repeat (12) @(negedge clk);
      chk(busy == 1'b0 && cs_n == 1'b1 && nbytes - base == 3, "R9",
          "no frame after busy start (busy,cs_n,bytes)",
          {busy, cs_n, 4'(nbytes - base)}, {2'b01, 4'd3});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerrors++;
    $display("FAIL all watchdog: actual cycles %0d expected below %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    logic [23:0] pats [0:3];
    int hs [0:4];
    int ss [0:4];
    int ds [0:4];
    pats[0] = 24'h000000; pats[1] = 24'hFFFFFF; pats[2] = 24'hA5C33C; pats[3] = 24'h123456;
    hs[0] = 0; ss[0] = 1; ds[0] = 1;
    hs[1] = 1; ss[1] = 3; ds[1] = 1;
    hs[2] = 3; ss[2] = 2; ds[2] = 5;
    hs[3] = 2; ss[3] = 4; ds[3] = 2;
    hs[4] = 15; ss[4] = 1; ds[4] = 3;

    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0 && tx_load == 1'b0 && tx_clr == 1'b0,
        "R1", "outputs in reset", {cs_n, busy, done, tx_load, tx_clr}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0 && tx_load == 1'b0 && tx_clr == 1'b0,
        "R1", "outputs after reset", {cs_n, busy, done, tx_load, tx_clr}, 5'b10000);

    // walking ones and patterns under every timing configuration (R3, R4, R5, R7)
    for (int c = 0; c < 5; c++) begin
      for (int b = 0; b < 24; b++) begin
        run_frame(24'(1) << b, hs[c], ss[c], ds[c], 1'b0, 0);
      end
      for (int p = 0; p < 4; p++) begin
        run_frame(pats[p], hs[c], ss[c], ds[c], 1'b0, 0);
      end
    end

    // hold count sweep (R7)
    for (int h = 0; h < 16; h++) begin
      run_frame(24'h3C5A96 ^ 24'(h), h, 2, 1, 1'b0, 0);
    end

    // stale completion flag at frame start (R6)
    run_frame(24'h0F1E2D, 0, 3, 1, 1'b1, 0);
    run_frame(24'hC0FFEE, 2, 1, 4, 1'b1, 0);

    // start pulses while busy (R9)
    for (int j = 1; j < 12; j += 2) begin
      run_frame(24'h5A5A5A ^ 24'(j), 1, 2, 2, 1'b0, j);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule